// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is one timer channel used to measure when things happen. A counter runs while the channel is enabled and a count-enable strobe is high. On chosen edges of the A pin, the block copies the running count into capture register A and then into capture register B. The difference between the two copies gives a pulse width or a period. The count can be restarted by a command, by an edge on a selectable trigger pin, or by a match against a compare register. When B is loaded, the counter can either be frozen until the next trigger or be switched off.

Software controls the channel through a flat word-addressed register port. Writes take effect at the clock edge. Reads return combinationally. A read of the status word clears its event bits. The address map is: 0 command (write), 1 mode, 2 count (read), 3 capture A (read), 4 capture B (read), 5 compare value, 6 status (read), 7 interrupt enable (write), 8 interrupt disable (write), 9 interrupt mask (read). Pins A and B are inputs only. Each pin passes through a two-stage synchronizer, and an edge is found by comparing two successive synchronized samples.

Top module: `cap_timer_chan`

## Requirements
- R1: After reset the count, the status word, the mode word, the interrupt mask and `irq` are all zero, and the channel is stopped.
- R2: Command bit 0 starts the channel and command bit 1 stops it; if both are written together, the stop wins. While the channel is running and `cnt_en` is high, the count rises by one per clock. While the channel is stopped or `cnt_en` is low, the count holds. Status bit 16 reads 1 while the channel is running.
- R3: Command bit 2 is a software trigger. It sets the count to 0 at the write edge, whether or not the channel is running, and re-arms the capture sequence so that register A is loaded next.
- R4: Mode bits [1:0] choose the A-pin edge that loads capture A: 0 none, 1 rising, 2 falling, 3 both. A pin change applied while the count reads N is captured as N+2 (two synchronizer stages, then one edge-detect cycle). A is loaded at most once between re-arms, and each load sets status bit 5.
- R5: Mode bits [3:2] choose, with the same encoding, the A-pin edge that loads capture B. B loads only after A has loaded, and a B load re-arms A. An edge that matches both fields while A is armed loads only A. Each B load sets status bit 6.
- R6: Status bit 1 (overrun) is set when A or B is loaded while its own loaded bit (5 or 6) is still set from an earlier load that has not been read.
- R7: If mode bit 4 is set, a B load freezes the count at its post-load value until the next trigger, and the channel stays running. If mode bit 5 is set, a B load stops the channel; status bit 16 then reads 0 and the count holds.
- R8: Mode bits [7:6] choose the external trigger edge, with the same encoding as R4. Mode bit 8 selects the trigger pin: 1 is pin A, 0 is pin B. While the channel is running, a matching edge sets the count to 0 and sets status bit 7. Edges on the unselected pin, or of the wrong type, are ignored.
- R9: Status bit 4 is set when the count steps onto the compare value. If mode bit 9 is also set, the step after the one that reaches the compare value returns the count to 0 and re-arms capture, so the count repeats with a period of compare+1.
- R10: A step from the all-ones count to 0 sets status bit 0 (overflow).
- R11: Reading status returns bits [7:0] and clears them at that edge. An event that occurs in the same cycle as the read is kept.
- R12: Writing interrupt enable sets the mask bits that are 1 in the data. Writing interrupt disable clears them. The mask reads back at address 9. `irq` is high whenever any status bit in [7:0] is set and also enabled in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-enable strobe standing in for the selected clock source |
| tioa | input | 1 | Pin A: capture input and optional trigger source |
| tiob | input | 1 | Pin B: optional trigger source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status on address 6) |
| reg_addr | input | 4 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The capture path is driven with a single high pulse on pin A under every pairing of the A and B edge fields that matters. These runs show whether the rising and falling edges are told apart, and whether "both" really means both. They also show that B waits for A and that A stays loaded until re-armed. A double pulse that is never read separates a fresh load from an overrun. Trigger tests raise edges on the selected pin and on the unselected pin, with matching and non-matching edge types, so that the pin select and the edge select are each shown to have an effect. The compare test and the full wrap to the all-ones value tell the compare restart apart from overflow, including the case where an event and a status read fall in the same cycle.

// File: rtl/cap_timer_pkg.sv
// Shared types for the capture-mode timer channel: register addresses,
// edge-select encoding, mode word layout and status bit positions.
package cap_timer_pkg;

    typedef enum logic [3:0] {
        RA_CMD   = 4'd0,
        RA_MODE  = 4'd1,
        RA_CNT   = 4'd2,
        RA_CAPA  = 4'd3,
        RA_CAPB  = 4'd4,
        RA_CMPC  = 4'd5,
        RA_STAT  = 4'd6,
        RA_IEN   = 4'd7,
        RA_IDIS  = 4'd8,
        RA_IMASK = 4'd9
    } reg_addr_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_ANY  = 2'd3
    } edge_sel_e;

    // Mode word, MSB first; bit 0 is the LSB of a_edge.
    typedef struct packed {
        logic      rc_restart;   // bit 9
        logic      trig_on_a;    // bit 8
        edge_sel_e trig_edge;    // bits 7:6
        logic      off_on_b;     // bit 5
        logic      hold_on_b;    // bit 4
        edge_sel_e b_edge;       // bits 3:2
        edge_sel_e a_edge;       // bits 1:0
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam int ST_W   = 8;
    localparam int ST_OVF = 0;
    localparam int ST_OVR = 1;
    localparam int ST_CMP = 4;
    localparam int ST_LDA = 5;
    localparam int ST_LDB = 6;
    localparam int ST_TRG = 7;
    localparam int ST_RUN = 16;

    // True when the observed edge matches the selected edge type.
    function automatic logic edge_hit(input edge_sel_e sel, input logic rise, input logic fall);
        case (sel)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_ANY:  edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cap_sync.sv
// Input synchronizer and edge detector.
// Each input goes through STAGES flops. One extra flop holds the previous
// synchronized sample, and rise/fall are true for one cycle when the two differ.
// Assumes inputs are asynchronous levels that are slow compared with clk.
module cap_sync #(
    parameter int N_IN   = 2,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] din,
    output logic [N_IN-1:0] rise,
    output logic [N_IN-1:0] fall
);
    localparam int CHAIN_W = STAGES + 1;

    for (genvar i = 0; i < N_IN; i++) begin : g_pin
        logic [CHAIN_W-1:0] chain_q;

        // Shift the pin through the synchronizer and the history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[CHAIN_W-2:0], din[i]};
        end

        assign rise[i] =  chain_q[STAGES-1] & ~chain_q[STAGES];
        assign fall[i] = ~chain_q[STAGES-1] &  chain_q[STAGES];
    end
endmodule

// File: rtl/cap_counter.sv
// Channel counter with run/hold control.
// It counts on cnt_en while running and not held. A trigger clears it, and
// the trigger takes priority over a step. With compare restart enabled, the
// step taken at the compare value returns the count to zero.
// Assumes start/stop/trigger inputs are single-cycle strobes.
module cap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start,
    input  logic             stop,
    input  logic             trig,
    input  logic             hold_set,
    input  logic             off_set,
    input  logic             rc_restart,
    input  logic [CNT_W-1:0] rc_val,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             active,
    output logic             cmp_evt,
    output logic             ovf_evt,
    output logic             rc_wrap
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             run_q;
    logic             hold_q;
    logic             tick;

    // Decode this cycle's step and the events it produces.
    always_comb begin
        tick    = cnt_en & run_q & ~hold_q;
        cnt_inc = cnt_q + 1'b1;
        rc_wrap = tick & ~trig & rc_restart & (cnt_q == rc_val);
        ovf_evt = tick & ~trig & ~rc_wrap & (cnt_q == '1);
        cmp_evt = tick & ~trig & ~rc_wrap & (cnt_inc == rc_val);
    end

    // Count register: trigger first, then compare restart, then step.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (trig || rc_wrap)  cnt_q <= '0;
        else if (tick)             cnt_q <= cnt_inc;
    end

    // Run flag: any stop source wins over a start.
    always_ff @(posedge clk) begin
        if (!rst_n)               run_q <= 1'b0;
        else if (stop || off_set) run_q <= 1'b0;
        else if (start)           run_q <= 1'b1;
    end

    // Hold flag: set on a B load in hold mode, released by a trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= 1'b0;
        else if (trig)     hold_q <= 1'b0;
        else if (hold_set) hold_q <= 1'b1;
    end

    assign cnt     = cnt_q;
    assign running = run_q;
    assign active  = run_q & ~hold_q;
endmodule

// File: rtl/cap_loader.sv
// Ordered capture sequencer.
// A loads first, and then B loads. A B load re-arms A. A re-arm clears the
// sequence and blocks any load in the same cycle.
// Assumes the edge hits are single-cycle pulses from the edge detector.
module cap_loader #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             enable,
    input  logic             rearm,
    input  logic             a_hit,
    input  logic             b_hit,
    output logic [CNT_W-1:0] cap_a,
    output logic [CNT_W-1:0] cap_b,
    output logic             load_a,
    output logic             load_b,
    output logic             a_done
);
    logic             a_done_q;
    logic [CNT_W-1:0] cap_a_q;
    logic [CNT_W-1:0] cap_b_q;

    assign load_a = enable & ~rearm & a_hit & ~a_done_q;
    assign load_b = enable & ~rearm & b_hit &  a_done_q;

    // Sequence state and the two capture registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_done_q <= 1'b0;
            cap_a_q  <= '0;
            cap_b_q  <= '0;
        end else if (load_a) begin
            cap_a_q  <= cnt;
            a_done_q <= 1'b1;
        end else if (load_b) begin
            cap_b_q  <= cnt;
            a_done_q <= 1'b0;
        end else if (rearm) begin
            a_done_q <= 1'b0;
        end
    end

    assign cap_a  = cap_a_q;
    assign cap_b  = cap_b_q;
    assign a_done = a_done_q;
endmodule

// File: rtl/cap_timer_chan.sv
// Capture-mode timer channel top.
// It holds the register bank (mode, compare value, status, interrupt mask),
// decodes the commands and the trigger, and joins the synchronizer, counter
// and capture sequencer. Reads are combinational. A status read clears the
// event bits at the edge, and a set in the same cycle wins over the clear.
// Assumes DATA_W >= CNT_W and DATA_W > ST_RUN.
module cap_timer_chan
    import cap_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              tioa,
    input  logic              tiob,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [3:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int PIN_A = 0;
    localparam int PIN_B = 1;

    mode_t            mode_q;
    logic [CNT_W-1:0] rc_q;
    logic [ST_W-1:0]  sts_q;
    logic [ST_W-1:0]  mask_q;
    logic [ST_W-1:0]  sts_set;

    logic             cmd_wr, mode_wr, cmpc_wr, ien_wr, idis_wr, stat_rd;
    logic             sw_trig, ext_trig, trig_any;
    logic [1:0]       pin_rise, pin_fall;
    logic             trig_pin_rise, trig_pin_fall;

    logic [CNT_W-1:0] cnt_val, cap_a, cap_b;
    logic             running, active, cmp_evt, ovf_evt, rc_wrap;
    logic             load_a, load_b, a_done;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:CNT_W];

    // Strobe decode for register writes and the clearing read.
    always_comb begin
        cmd_wr  = reg_wr && (reg_addr == RA_CMD);
        mode_wr = reg_wr && (reg_addr == RA_MODE);
        cmpc_wr = reg_wr && (reg_addr == RA_CMPC);
        ien_wr  = reg_wr && (reg_addr == RA_IEN);
        idis_wr = reg_wr && (reg_addr == RA_IDIS);
        stat_rd = reg_rd && (reg_addr == RA_STAT);
    end

    cap_sync #(.N_IN(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({tiob, tioa}),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    // Trigger sources: software command, or the selected pin edge while running.
    always_comb begin
        trig_pin_rise = mode_q.trig_on_a ? pin_rise[PIN_A] : pin_rise[PIN_B];
        trig_pin_fall = mode_q.trig_on_a ? pin_fall[PIN_A] : pin_fall[PIN_B];
        sw_trig       = cmd_wr & reg_wdata[2];
        ext_trig      = running & edge_hit(mode_q.trig_edge, trig_pin_rise, trig_pin_fall);
        trig_any      = sw_trig | ext_trig;
    end

    cap_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (cnt_en),
        .start     (cmd_wr & reg_wdata[0]),
        .stop      (cmd_wr & reg_wdata[1]),
        .trig      (trig_any),
        .hold_set  (load_b & mode_q.hold_on_b),
        .off_set   (load_b & mode_q.off_on_b),
        .rc_restart(mode_q.rc_restart),
        .rc_val    (rc_q),
        .cnt       (cnt_val),
        .running   (running),
        .active    (active),
        .cmp_evt   (cmp_evt),
        .ovf_evt   (ovf_evt),
        .rc_wrap   (rc_wrap)
    );

    cap_loader #(.CNT_W(CNT_W)) u_loader (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (cnt_val),
        .enable(active),
        .rearm (trig_any | rc_wrap),
        .a_hit (edge_hit(mode_q.a_edge, pin_rise[PIN_A], pin_fall[PIN_A])),
        .b_hit (edge_hit(mode_q.b_edge, pin_rise[PIN_A], pin_fall[PIN_A])),
        .cap_a (cap_a),
        .cap_b (cap_b),
        .load_a(load_a),
        .load_b(load_b),
        .a_done(a_done)
    );

    // Gather this cycle's status events.
    always_comb begin
        sts_set         = '0;
        sts_set[ST_OVF] = ovf_evt;
        sts_set[ST_OVR] = (load_a & sts_q[ST_LDA]) | (load_b & sts_q[ST_LDB]);
        sts_set[ST_CMP] = cmp_evt;
        sts_set[ST_LDA] = load_a;
        sts_set[ST_LDB] = load_b;
        sts_set[ST_TRG] = ext_trig;
    end

    // Sticky status: clear on read, new events override the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (stat_rd ? '0 : sts_q) | sts_set;
    end

    // Mode word and compare value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            rc_q   <= '0;
        end else begin
            if (mode_wr) mode_q <= mode_t'(reg_wdata[MODE_W-1:0]);
            if (cmpc_wr) rc_q   <= reg_wdata[CNT_W-1:0];
        end
    end

    // Interrupt mask: set by enable writes, cleared by disable writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (ien_wr)  mask_q <= mask_q | reg_wdata[ST_W-1:0];
        else if (idis_wr) mask_q <= mask_q & ~reg_wdata[ST_W-1:0];
    end

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE:  reg_rdata[MODE_W-1:0] = mode_q;
            RA_CNT:   reg_rdata[CNT_W-1:0]  = cnt_val;
            RA_CAPA:  reg_rdata[CNT_W-1:0]  = cap_a;
            RA_CAPB:  reg_rdata[CNT_W-1:0]  = cap_b;
            RA_CMPC:  reg_rdata[CNT_W-1:0]  = rc_q;
            RA_STAT: begin
                reg_rdata[ST_W-1:0] = sts_q;
                reg_rdata[ST_RUN]   = running;
            end
            RA_IMASK: reg_rdata[ST_W-1:0]   = mask_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = |(sts_q & mask_q);
endmodule

// File: rtl/cap_timer_chk.sv
// Property checker for the capture-mode timer channel, bound to the top.
module cap_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             trig_any,
    input logic             sw_trig,
    input logic [CNT_W-1:0] cnt,
    input logic             load_a,
    input logic             load_b,
    input logic             a_done,
    input logic [7:0]       sts,
    input logic [7:0]       mask,
    input logic             ien_wr,
    input logic [7:0]       wdata_lo
);
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !trig_any) |=> $stable(cnt));

    p_swtrig_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> (cnt == '0));

    p_a_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_a |=> (a_done && !load_a));

    p_b_after_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_b |-> a_done);

    p_wrap_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts[0]) |-> (cnt == '0));

    p_mask_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ien_wr |=> ((mask & $past(wdata_lo)) == $past(wdata_lo)));
endmodule

bind cap_timer_chan cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (cnt_en),
    .trig_any(trig_any),
    .sw_trig (sw_trig),
    .cnt     (cnt_val),
    .load_a  (load_a),
    .load_b  (load_b),
    .a_done  (a_done),
    .sts     (sts_q),
    .mask    (mask_q),
    .ien_wr  (ien_wr),
    .wdata_lo(reg_wdata[7:0])
);

// File: tb/tb_cap_timer_chan.sv
`timescale 1ns/1ps
module tb_cap_timer_chan;
    localparam logic [3:0] A_CMD = 4'd0, A_MODE = 4'd1, A_CNT = 4'd2, A_CAPA = 4'd3,
                           A_CAPB = 4'd4, A_CMPC = 4'd5, A_STAT = 4'd6, A_IEN = 4'd7,
                           A_IDIS = 4'd8, A_IMASK = 4'd9;

    typedef struct packed {
        logic [1:0]  a_e;
        logic [1:0]  b_e;
        logic        exp_a;
        logic        exp_b;
        logic [15:0] cap_a;
        logic [15:0] cap_b;
    } vec_t;

    // One pulse on pin A: rising at count 5, falling at count 20.
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd2, 1'b1, 1'b1, 16'd7,  16'd22},
        '{2'd2, 2'd1, 1'b1, 1'b0, 16'd22, 16'd0},
        '{2'd3, 2'd3, 1'b1, 1'b1, 16'd7,  16'd22},
        '{2'd1, 2'd1, 1'b1, 1'b0, 16'd7,  16'd0},
        '{2'd0, 2'd1, 1'b0, 1'b0, 16'd0,  16'd0},
        '{2'd3, 2'd0, 1'b1, 1'b0, 16'd7,  16'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n, cnt_en, tioa, tiob, reg_wr, reg_rd, irq;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, d;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cap_timer_chan dut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tioa(tioa), .tiob(tiob),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Called at a negedge; samples combinational read data, then ends at the next negedge.
    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cnt_en = 1'b0; tioa = 1'b0; tiob = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        wait_n(4);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_STAT, d);  check("R1 status", d, 32'h0);
        rd(A_CNT, d);   check("R1 count", d, 32'h0);
        rd(A_MODE, d);  check("R1 mode", d, 32'h0);
        rd(A_IMASK, d); check("R1 mask", d, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2: run control and count enable
        cnt_en = 1'b1;
        wait_n(5);
        rd(A_CNT, d);   check("R2 not running", d, 32'd0);
        wr(A_CMD, 32'h1);
        wait_n(9);
        rd(A_CNT, d);   check("R2 counting", d, 32'd9);
        cnt_en = 1'b0;
        wait_n(4);
        rd(A_CNT, d);   check("R2 cnt_en low holds", d, 32'd10);
        cnt_en = 1'b1;
        wr(A_CMD, 32'h2);
        wait_n(5);
        rd(A_CNT, d);   check("R2 stopped holds", d, 32'd11);
        rd(A_STAT, d);  check("R2 run flag off", {31'h0, d[16]}, 32'h0);
        wr(A_CMD, 32'h3);
        wait_n(3);
        rd(A_CNT, d);   check("R2 stop wins", d, 32'd11);
        wr(A_CMD, 32'h1);
        wait_n(3);
        rd(A_CNT, d);   check("R2 resumed", d, 32'd14);

        // R3: software trigger
        wr(A_CMD, 32'h4);
        rd(A_CNT, d);   check("R3 trigger zeroes count", d, 32'd0);

        // R4/R5: table of edge-select pairs
        for (int i = 0; i < NV; i++) begin
            rd(A_STAT, d);
            wr(A_MODE, {28'h0, VECS[i].b_e, VECS[i].a_e});
            wr(A_CMD, 32'h4);
            wait_n(5);
            tioa = 1'b1;
            wait_n(15);
            tioa = 1'b0;
            wait_n(6);
            rd(A_STAT, d);
            check($sformatf("R4 vec%0d A loaded", i), {31'h0, d[5]}, {31'h0, VECS[i].exp_a});
            check($sformatf("R5 vec%0d B loaded", i), {31'h0, d[6]}, {31'h0, VECS[i].exp_b});
            check($sformatf("R6 vec%0d no overrun", i), {31'h0, d[1]}, 32'h0);
            rd(A_CAPA, d);
            if (VECS[i].exp_a) check($sformatf("R4 vec%0d capture A", i), d, {16'h0, VECS[i].cap_a});
            rd(A_CAPB, d);
            if (VECS[i].exp_b) check($sformatf("R5 vec%0d capture B", i), d, {16'h0, VECS[i].cap_b});
        end

        // R6: two pulses without a status read
        rd(A_STAT, d);
        wr(A_MODE, 32'h9);
        wr(A_CMD, 32'h4);
        wait_n(5);  tioa = 1'b1;
        wait_n(5);  tioa = 1'b0;
        wait_n(5);  tioa = 1'b1;
        wait_n(5);  tioa = 1'b0;
        wait_n(6);
        rd(A_STAT, d);  check("R6 overrun with loads", d[7:0], 32'h62);
        rd(A_CAPA, d);  check("R6 second A capture", d, 32'd17);
        rd(A_STAT, d);  check("R11 cleared by read", d[7:0], 32'h0);
        check("R11 run flag", {31'h0, d[16]}, 32'h1);

        // R7: freeze on B load
        wr(A_MODE, 32'h19);
        wr(A_CMD, 32'h4);
        wait_n(5);  tioa = 1'b1;
        wait_n(15); tioa = 1'b0;
        wait_n(6);
        rd(A_CNT, d);   check("R7 held after B", d, 32'd23);
        rd(A_STAT, d);  check("R7 still running", {31'h0, d[16]}, 32'h1);
        wr(A_CMD, 32'h4);
        wait_n(3);
        rd(A_CNT, d);   check("R7 trigger releases hold", d, 32'd3);

        // R7: stop channel on B load
        wr(A_MODE, 32'h29);
        wr(A_CMD, 32'h4);
        wait_n(5);  tioa = 1'b1;
        wait_n(15); tioa = 1'b0;
        wait_n(6);
        rd(A_CNT, d);   check("R7 stopped at B", d, 32'd23);
        rd(A_STAT, d);  check("R7 run flag cleared", {31'h0, d[16]}, 32'h0);
        wr(A_CMD, 32'h1);
        wait_n(2);
        rd(A_CNT, d);   check("R7 restart counts", d, 32'd25);

        // R8: rising edge on pin B as trigger
        rd(A_STAT, d);
        wr(A_MODE, 32'h40);
        wr(A_CMD, 32'h4);
        wait_n(10); tiob = 1'b1;
        wait_n(7);
        rd(A_CNT, d);   check("R8 pin B rise restarts", d, 32'd4);
        rd(A_STAT, d);  check("R8 trigger flag", {31'h0, d[7]}, 32'h1);
        tiob = 1'b0;
        wait_n(6);
        rd(A_STAT, d);  check("R8 falling ignored", {31'h0, d[7]}, 32'h0);

        // R8: falling edge on pin A as trigger
        wr(A_MODE, 32'h180);
        tioa = 1'b1;
        wait_n(6);
        wr(A_CMD, 32'h4);
        wait_n(10); tioa = 1'b0;
        wait_n(7);
        rd(A_CNT, d);   check("R8 pin A fall restarts", d, 32'd4);
        rd(A_STAT, d);  check("R8 trigger flag pin A", {31'h0, d[7]}, 32'h1);
        tiob = 1'b1;
        wait_n(6);
        rd(A_STAT, d);  check("R8 pin B ignored", {31'h0, d[7]}, 32'h0);
        tiob = 1'b0;

        // R9: compare flag and compare restart
        wr(A_CMPC, 32'd9);
        wr(A_MODE, 32'h200);
        rd(A_STAT, d);
        wr(A_CMD, 32'h4);
        wait_n(25);
        rd(A_CNT, d);   check("R9 period of compare+1", d, 32'd5);
        rd(A_STAT, d);  check("R9 compare flag", {31'h0, d[4]}, 32'h1);
        wr(A_MODE, 32'h0);
        wr(A_CMD, 32'h4);
        wait_n(25);
        rd(A_CNT, d);   check("R9 no restart when off", d, 32'd25);
        rd(A_STAT, d);  check("R9 compare flag free run", {31'h0, d[4]}, 32'h1);

        // R10: overflow; R11 set wins over same-cycle clear
        rd(A_STAT, d);
        wr(A_CMD, 32'h4);
        wait_n(65535);
        rd(A_STAT, d);  check("R10 no overflow before wrap", {31'h0, d[0]}, 32'h0);
        rd(A_STAT, d);  check("R11 R10 overflow kept over clear", {31'h0, d[0]}, 32'h1);
        rd(A_CNT, d);   check("R10 count after wrap", d, 32'd1);

        // R12: interrupt mask and irq
        wr(A_IEN, 32'h20);
        rd(A_IMASK, d); check("R12 mask set", d, 32'h20);
        rd(A_STAT, d);
        check("R12 irq idle", {31'h0, irq}, 32'h0);
        wr(A_MODE, 32'h1);
        wr(A_CMD, 32'h4);
        wait_n(5);  tioa = 1'b1;
        wait_n(6);
        check("R12 irq on A load", {31'h0, irq}, 32'h1);
        wr(A_IDIS, 32'h20);
        check("R12 irq masked off", {31'h0, irq}, 32'h0);
        rd(A_IMASK, d); check("R12 mask cleared", d, 32'h0);
        tioa = 1'b0;
        wait_n(4);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule